// File: doc/BRIEF.md
# Dual-Bank Paired Register File

This block is the general-purpose register storage of a datapath: two independent banks, A and B, each holding sixteen 32-bit registers. Functional units read operands through four read ports and retire results through two write ports. Each port names its bank, its register index and whether the access is short (one 32-bit register) or long (a 40-bit operand).

A long operand always occupies an even register and the odd register directly above it. The even register holds bits 31:0 and bits 7:0 of the odd register hold bits 39:32. A long access with an odd index is refused and flagged on the same cycle. Reads are combinational and writes land on the rising clock edge, so a register written in a cycle still reads its old value during that cycle.

Top module: `dual_bank_regfile`

## Requirements
- R1: The two banks are separate. Bank select 0 chooses bank A and 1 chooses bank B. A write to register n of one bank leaves register n of the other bank unchanged.
- R2: A short write (long flag 0) stores wr_data bits 31:0 into the indexed register at the rising edge. Bits 39:32 of the write data are ignored and the odd neighbour is not touched. A short read returns the register zero-extended, with bits 39:32 of the 40-bit read data equal to 0.
- R3: A long write with an even index stores data bits 31:0 in the even register. The odd register above it becomes {24'b0, data[39:32]}, so its bits 31:8 are cleared.
- R4: A long read with an even index returns {odd[7:0], even[31:0]} on the 40-bit read data.
- R5: A long access with an odd index (index bit 0 = 1) is an error. For a write, wr_err is high in that same cycle and no register changes. For a read, rd_err is high and the read data is 0.
- R6: A read of a register that is being written in the same cycle returns the old value. The new value is visible in the cycle after the edge.
- R7: A synchronous active-high reset clears all 32 registers to zero.
- R8: The four read ports work independently and at the same time. Overlapping pairs and the same pair read by two ports return consistent data.
- R9: When both write ports write the same register in one cycle, write port 1 (the higher-numbered port) wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes land on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 2 | Write enable, one bit per write port |
| wr_long | input | 2 | Long-operand flag per write port |
| wr_bank | input | 2 | Bank select per write port (0 = A, 1 = B) |
| wr_idx | input | 8 | Register index, 4 bits per write port (port k at bits 4k+3:4k) |
| wr_data | input | 80 | Write data, 40 bits per write port (port k at bits 40k+39:40k) |
| wr_err | output | 2 | High while an enabled long write has an odd index |
| rd_bank | input | 4 | Bank select per read port |
| rd_long | input | 4 | Long-operand flag per read port |
| rd_idx | input | 16 | Register index, 4 bits per read port |
| rd_data | output | 160 | Read data, 40 bits per read port |
| rd_err | output | 4 | High while a long read has an odd index |

## Verification
A corrupted register shows up on the read ports as soon as any port addresses it, in the same cycle, because reads are combinational. A write that lands in the wrong bank, the wrong half of a pair or the wrong priority order becomes visible one cycle after its clock edge. A leftover upper byte in an odd register appears as nonzero bits 31:8 on a short read of that register. A refused odd long write that still stored data appears on the next read of the two registers around it.

// File: rtl/dual_bank_regfile.sv
module dual_bank_regfile #(
  parameter int NBANK = 2,
  parameter int NREG  = 16,
  parameter int W     = 32,
  parameter int XW    = 8,
  parameter int NWR   = 2,
  parameter int NRD   = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NWR-1:0]                 wr_en,
  input  logic [NWR-1:0]                 wr_long,
  input  logic [NWR*$clog2(NBANK)-1:0]   wr_bank,
  input  logic [NWR*$clog2(NREG)-1:0]    wr_idx,
  input  logic [NWR*(W+XW)-1:0]          wr_data,
  output logic [NWR-1:0]                 wr_err,
  input  logic [NRD*$clog2(NBANK)-1:0]   rd_bank,
  input  logic [NRD-1:0]                 rd_long,
  input  logic [NRD*$clog2(NREG)-1:0]    rd_idx,
  output logic [NRD*(W+XW)-1:0]          rd_data,
  output logic [NRD-1:0]                 rd_err
);
  localparam int BW   = $clog2(NBANK);
  localparam int IW   = $clog2(NREG);
  localparam int AW   = BW + IW;
  localparam int LW   = W + XW;
  localparam int NENT = NBANK * NREG;
  localparam logic [AW-1:0] ODD = AW'(1);

  logic [W-1:0]  rf [NENT];
  logic [AW-1:0] wa [NWR];
  logic [AW-1:0] ra [NRD];

  for (genvar w = 0; w < NWR; w++) begin : g_wr
    assign wa[w]     = {wr_bank[w*BW +: BW], wr_idx[w*IW +: IW]};
    assign wr_err[w] = wr_en[w] & wr_long[w] & wr_idx[w*IW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NENT; i++) rf[i] <= '0;
    end else begin
      for (int w = 0; w < NWR; w++) begin
        if (wr_en[w] && !wr_err[w]) begin
          rf[wa[w]] <= wr_data[w*LW +: W];
          if (wr_long[w])
            rf[wa[w] | ODD] <= {{(W-XW){1'b0}}, wr_data[w*LW+W +: XW]};
        end
      end
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign ra[r]     = {rd_bank[r*BW +: BW], rd_idx[r*IW +: IW]};
    assign rd_err[r] = rd_long[r] & rd_idx[r*IW];
    assign rd_data[r*LW +: LW] = rd_err[r]  ? '0 :
                                 rd_long[r] ? {rf[ra[r] | ODD][XW-1:0], rf[ra[r]]} :
                                              {{XW{1'b0}}, rf[ra[r]]};

    p_short_zext_r2: assert property (@(posedge clk) disable iff (rst)
      !rd_long[r] |-> rd_data[r*LW+W +: XW] == '0);
  end

  logic any_nz;
  always_comb begin
    any_nz = 1'b0;
    for (int i = 0; i < NENT; i++) any_nz = any_nz | (|rf[i]);
  end

  p_reset_clears_r7: assert property (@(posedge clk)
    rst |=> !any_nz);

  for (genvar w = 0; w < NWR; w++) begin : g_chk
    logic solo;
    assign solo = (wr_en == (NWR'(1) << w));

    p_err_no_write_r5: assert property (@(posedge clk) disable iff (rst)
      solo && wr_err[w] |=> rf[$past(wa[w])] == $past(rf[wa[w]]) &&
                            rf[$past(wa[w]) & ~ODD] == $past(rf[wa[w] & ~ODD]));

    p_long_low_r3: assert property (@(posedge clk) disable iff (rst)
      solo && wr_long[w] && !wr_err[w] |=> rf[$past(wa[w])] == $past(wr_data[w*LW +: W]));

    p_long_high_r3: assert property (@(posedge clk) disable iff (rst)
      solo && wr_long[w] && !wr_err[w] |=>
        rf[$past(wa[w]) | ODD] == {{(W-XW){1'b0}}, $past(wr_data[w*LW+W +: XW])});
  end

  p_last_port_wins_r9: assert property (@(posedge clk) disable iff (rst)
    wr_en[NWR-1] && !wr_err[NWR-1] |=>
      rf[$past(wa[NWR-1])] == $past(wr_data[(NWR-1)*LW +: W]));
endmodule

// File: tb/dual_bank_regfile_bench.sv
`timescale 1ns/1ps
module dual_bank_regfile_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   wr_en = '0, wr_long = '0, wr_bank = '0, wr_err;
  logic [7:0]   wr_idx = '0;
  logic [79:0]  wr_data = '0;
  logic [3:0]   rd_bank = '0, rd_long = '0, rd_err;
  logic [15:0]  rd_idx = '0;
  logic [159:0] rd_data;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  dual_bank_regfile u_dual_bank_regfile (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_long(wr_long), .wr_bank(wr_bank), .wr_idx(wr_idx),
    .wr_data(wr_data), .wr_err(wr_err),
    .rd_bank(rd_bank), .rd_long(rd_long), .rd_idx(rd_idx),
    .rd_data(rd_data), .rd_err(rd_err));

  // {bank, long, idx, data[39:0], expected even/indexed reg, expected odd reg}
  localparam logic [109:0] VEC [6] = '{
    {1'b0, 1'b1, 4'd2,  40'hAB_1234_5678, 32'h1234_5678, 32'h0000_00AB},
    {1'b1, 1'b0, 4'd2,  40'hFF_DEAD_BEEF, 32'hDEAD_BEEF, 32'h0000_0000},
    {1'b0, 1'b0, 4'd3,  40'h00_FFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000},
    {1'b0, 1'b1, 4'd2,  40'h5A_0000_0001, 32'h0000_0001, 32'h0000_005A},
    {1'b1, 1'b1, 4'd14, 40'h01_CAFE_F00D, 32'hCAFE_F00D, 32'h0000_0001},
    {1'b0, 1'b0, 4'd15, 40'h00_0000_0077, 32'h0000_0077, 32'h0000_0000}
  };

  task automatic check(string req, logic [39:0] act, logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_wr(int p, logic en, logic bank, logic lng, logic [3:0] idx, logic [39:0] d);
    wr_en[p] = en; wr_bank[p] = bank; wr_long[p] = lng;
    wr_idx[p*4 +: 4] = idx; wr_data[p*40 +: 40] = d;
  endtask

  task automatic set_rd(int p, logic bank, logic lng, logic [3:0] idx);
    rd_bank[p] = bank; rd_long[p] = lng; rd_idx[p*4 +: 4] = idx;
  endtask

  function automatic logic [39:0] rdp(int p);
    return rd_data[p*40 +: 40];
  endfunction

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    set_rd(0, 0, 0, 4'd0); set_rd(1, 1, 0, 4'd15); set_rd(2, 0, 1, 4'd8); set_rd(3, 1, 1, 4'd4);
    #1;
    check("R7 reset A0", rdp(0), 40'h0);
    check("R7 reset B15", rdp(1), 40'h0);
    check("R7 reset A9:8", rdp(2), 40'h0);
    check("R7 reset B5:4", rdp(3), 40'h0);

    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      set_wr(0, 1, VEC[i][109], VEC[i][108], VEC[i][107:104], VEC[i][103:64]);
      @(posedge clk); #1;
      set_wr(0, 0, 0, 0, 4'd0, 40'h0);
      set_rd(0, VEC[i][109], 0, VEC[i][107:104]);
      set_rd(1, VEC[i][109], 0, VEC[i][107:104] | 4'd1);
      set_rd(2, VEC[i][109], 1, VEC[i][107:104] & 4'hE);
      #1;
      check("R2 indexed register", rdp(0), {8'h0, VEC[i][63:32]});
      if (VEC[i][108]) begin
        check("R3 odd register", rdp(1), {8'h0, VEC[i][31:0]});
        check("R4 long read", rdp(2), {VEC[i][7:0], VEC[i][63:32]});
      end
    end

    set_rd(0, 1, 0, 4'd3); set_rd(1, 0, 0, 4'd14); #1;
    check("R2 short write left B3", rdp(0), 40'h0);
    check("R1 bank A14 untouched", rdp(1), 40'h0);
    set_rd(0, 0, 0, 4'd2); set_rd(1, 1, 0, 4'd2); #1;
    check("R1 A2", rdp(0), 40'h01);
    check("R1 B2", rdp(1), 40'h00_DEAD_BEEF);

    @(negedge clk);
    set_wr(0, 1, 0, 1, 4'd5, 40'hEE_1111_2222); #1;
    check("R5 wr_err", {38'h0, wr_err}, 40'h1);
    @(posedge clk); #1;
    set_wr(0, 0, 0, 0, 4'd0, 40'h0);
    set_rd(0, 0, 0, 4'd5); set_rd(1, 0, 0, 4'd4); set_rd(2, 0, 0, 4'd6); set_rd(3, 0, 1, 4'd5); #1;
    check("R5 A5 unchanged", rdp(0), 40'h0);
    check("R5 A4 unchanged", rdp(1), 40'h0);
    check("R5 A6 unchanged", rdp(2), 40'h0);
    check("R5 odd long read data", rdp(3), 40'h0);
    check("R5 rd_err", {36'h0, rd_err}, 40'h8);
    check("R5 wr_err cleared", {38'h0, wr_err}, 40'h0);

    @(negedge clk);
    set_wr(0, 1, 0, 0, 4'd7, 40'h11);
    set_rd(0, 0, 0, 4'd7); #5;
    check("R6 old value during write", rdp(0), 40'h0);
    @(posedge clk); #1;
    set_wr(0, 0, 0, 0, 4'd0, 40'h0); #1;
    check("R6 new value after edge", rdp(0), 40'h11);

    set_rd(0, 0, 1, 4'd2); set_rd(1, 0, 1, 4'd2); set_rd(2, 0, 0, 4'd3); set_rd(3, 1, 1, 4'd14); #1;
    check("R8 port0 A3:2", rdp(0), 40'h5A_0000_0001);
    check("R8 port1 A3:2", rdp(1), 40'h5A_0000_0001);
    check("R8 port2 A3", rdp(2), 40'h00_0000_005A);
    check("R8 port3 B15:14", rdp(3), 40'h01_CAFE_F00D);

    @(negedge clk);
    set_wr(0, 1, 1, 0, 4'd9, 40'h1);
    set_wr(1, 1, 1, 0, 4'd9, 40'h2);
    @(posedge clk); #1;
    set_rd(0, 1, 0, 4'd9); #1;
    check("R9 port1 wins same reg", rdp(0), 40'h2);
    @(negedge clk);
    set_wr(0, 1, 1, 1, 4'd8, 40'h33_4444_5555);
    set_wr(1, 1, 1, 0, 4'd9, 40'h66);
    @(posedge clk); #1;
    set_wr(0, 0, 0, 0, 4'd0, 40'h0); set_wr(1, 0, 0, 0, 4'd0, 40'h0);
    set_rd(0, 1, 0, 4'd9); set_rd(1, 1, 0, 4'd8); #1;
    check("R9 port1 wins over pair odd half", rdp(0), 40'h66);
    check("R9 port0 even half kept", rdp(1), 40'h00_4444_5555);

    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1; rst = 1'b0;
    set_rd(0, 0, 1, 4'd2); set_rd(1, 1, 1, 4'd14); set_rd(2, 0, 0, 4'd7); set_rd(3, 1, 0, 4'd9); #1;
    check("R7 reset clears A3:2", rdp(0), 40'h0);
    check("R7 reset clears B15:14", rdp(1), 40'h0);
    check("R7 reset clears A7", rdp(2), 40'h0);
    check("R7 reset clears B9", rdp(3), 40'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule